// File: doc/BRIEF.md
# SD Bus Command Timing Monitor

This block watches an SD/MMC bus from the side and checks the spacing between bus phases. It does not drive or decode the bus. Other logic hands it one-cycle event pulses: command start, command end, response start, response end, read-data start, write-data start, stop-command end and busy end. The block counts bus clock cycles from each reference event. When a later event arrives too early or too late, or an expected event never arrives, it raises the flag for the rule that was broken.

Distances are counted in bus clock edges. If event A is sampled at edge t and event B at edge t+d, then the distance is d. Every rule flag is registered, so it is high during the single cycle that follows the edge where the rule was broken. The read-access limit comes in as an input holding a cycle count. It is computed outside the block as the card's access time converted to clocks plus one hundred times the card's clock-based access byte. An identification-phase input selects the fixed response spacing that applies during card identification. That input is captured when a command ends.

Top module: `sd_timing_monitor`

## Requirements
- R1: With `id_phase` low at command end, a `rsp_start` at distance d from the last `cmd_end` raises `err_rsp_lat` for one cycle when d < 2 or d > 64. No flag is raised for 2 ≤ d ≤ 64.
- R2: If no response starts after a command, `err_rsp_lat` is raised exactly once, at distance 65. Any `rsp_start` that arrives later, with no response pending, is ignored.
- R3: With `id_phase` high at command end, the response must start at distance exactly 5. Any other distance, or no response by distance 6, raises `err_id_lat` exactly once, and `err_rsp_lat` is not raised.
- R4: A `rd_start` at distance d from the last `cmd_end` raises `err_rd_acc` when d < 2 or d > `acc_limit`. A `rd_start` before any command has ended is ignored.
- R5: A `cmd_start` at distance d < 8 from the last `rsp_end` raises `err_rsp_to_cmd`.
- R6: A `cmd_start` at distance d < 8 from the last `cmd_end` raises `err_cmd_to_cmd`.
- R7: A `wr_start` at distance d < 2 from the last `rsp_end` raises `err_wr_gap`.
- R8: A `busy_end` must follow `stop_end` at distance exactly 2. Any other distance, or no `busy_end` by distance 3, raises `err_stop_gap` exactly once. A `busy_end` with no stop pending is ignored.
- R9: The distance counters saturate at 2^CNT_W−1 and do not wrap. A read that starts long after its command is therefore still reported as late.
- R10: After reset all rule flags and `err_any` are 0. `err_any` goes high together with the first rule flag and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_phase | input | 1 | Identification phase; captured at command end |
| acc_limit | input | CNT_W | Maximum read access distance in cycles |
| cmd_start | input | 1 | Command start pulse |
| cmd_end | input | 1 | Command end pulse |
| rsp_start | input | 1 | Response start pulse |
| rsp_end | input | 1 | Response end pulse |
| rd_start | input | 1 | Read data start pulse |
| wr_start | input | 1 | Write data start pulse |
| stop_end | input | 1 | Stop command end pulse |
| busy_end | input | 1 | Busy / data release after stop |
| err_rsp_lat | output | 1 | Response latency violation |
| err_id_lat | output | 1 | Identification response violation |
| err_rd_acc | output | 1 | Read access window violation |
| err_rsp_to_cmd | output | 1 | Response-to-command gap too short |
| err_cmd_to_cmd | output | 1 | Command-to-command gap too short |
| err_wr_gap | output | 1 | Response-to-write gap too short |
| err_stop_gap | output | 1 | Stop spacing violation |
| err_any | output | 1 | Sticky summary of all flags |

## Verification
The hardest state to reach from the ports is a timeout. A timeout happens only when nothing arrives. The bench also has to show that a response arriving after a timeout does not raise a second flag, and that a counter stuck at its ceiling has not wrapped. For every rule, the bench sweeps the distance between the two events across the whole window and some way past it, then counts the pulses on the rule's flag over a long idle tail. This way a timeout and the late event that follows it show up in the same count. Saturation is reached by building the bench with a narrow counter and starting a read more than one full counter range after its command.

// File: rtl/sd_tm_pkg.sv
package sd_tm_pkg;
  // True when distance d lies inside the closed window [lo, hi].
  function automatic logic win_ok(input int unsigned d, input int unsigned lo,
                                  input int unsigned hi);
    return (d >= lo) && (d <= hi);
  endfunction

  // True when distance d is shorter than the required minimum.
  function automatic logic too_close(input int unsigned d, input int unsigned lo);
    return d < lo;
  endfunction

  // Reference event slots for the distance counters.
  localparam int REF_CMD  = 0;
  localparam int REF_RSP  = 1;
  localparam int REF_STOP = 2;
  localparam int NREF     = 3;
endpackage

// File: rtl/sd_tm_gap_counter.sv
module sd_tm_gap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic [W-1:0] cnt,
  output logic         vld
);
  localparam logic [W-1:0] CEIL = '1;

  // The cycle after load, cnt reads 1. It then climbs and stops at CEIL.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      vld <= 1'b0;
    end else if (load) begin
      cnt <= W'(1);
      vld <= 1'b1;
    end else if (vld && cnt != CEIL) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sd_tm_pend.sv
module sd_tm_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/sd_timing_monitor.sv
module sd_timing_monitor
  import sd_tm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RSP_MIN     = 2,
  parameter int RSP_MAX     = 64,
  parameter int ID_GAP      = 5,
  parameter int RD_MIN      = 2,
  parameter int RSP2CMD_MIN = 8,
  parameter int CMD2CMD_MIN = 8,
  parameter int WR_MIN      = 2,
  parameter int STOP_GAP    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_phase,
  input  logic [CNT_W-1:0] acc_limit,
  input  logic             cmd_start,
  input  logic             cmd_end,
  input  logic             rsp_start,
  input  logic             rsp_end,
  input  logic             rd_start,
  input  logic             wr_start,
  input  logic             stop_end,
  input  logic             busy_end,
  output logic             err_rsp_lat,
  output logic             err_id_lat,
  output logic             err_rd_acc,
  output logic             err_rsp_to_cmd,
  output logic             err_cmd_to_cmd,
  output logic             err_wr_gap,
  output logic             err_stop_gap,
  output logic             err_any
);
  localparam int unsigned RSP_TMO  = RSP_MAX + 1;
  localparam int unsigned ID_TMO   = ID_GAP + 1;
  localparam int unsigned STOP_TMO = STOP_GAP + 1;

  // Distance counters, one per reference event.
  logic [NREF-1:0]  ref_load;
  logic [CNT_W-1:0] gap     [NREF];
  logic [NREF-1:0]  gap_vld;

  assign ref_load[REF_CMD]  = cmd_end;
  assign ref_load[REF_RSP]  = rsp_end;
  assign ref_load[REF_STOP] = stop_end;

  for (genvar g = 0; g < NREF; g++) begin : g_gap
    sd_tm_gap_counter #(.W(CNT_W)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ref_load[g]),
      .cnt  (gap[g]),
      .vld  (gap_vld[g])
    );
  end

  // Named views of the counters, used by the assertions as well.
  logic [CNT_W-1:0] gap_cmd, gap_rsp, gap_stop;
  logic             vld_cmd, vld_rsp;
  int unsigned      d_cmd, d_rsp, d_stop;
  assign gap_cmd  = gap[REF_CMD];
  assign gap_rsp  = gap[REF_RSP];
  assign gap_stop = gap[REF_STOP];
  assign vld_cmd  = gap_vld[REF_CMD];
  assign vld_rsp  = gap_vld[REF_RSP];
  assign d_cmd    = 32'(gap_cmd);
  assign d_rsp    = 32'(gap_rsp);
  assign d_stop   = 32'(gap_stop);

  // Identification mode is captured when the command ends.
  logic id_lat;
  always_ff @(posedge clk) begin
    if (!rst_n)       id_lat <= 1'b0;
    else if (cmd_end) id_lat <= id_phase;
  end

  // Response pending tracker and timeout.
  logic        rsp_pend, rsp_tmo, rsp_bad;
  int unsigned rsp_lo, rsp_hi, rsp_tmo_at;
  assign rsp_lo     = id_lat ? ID_GAP : RSP_MIN;
  assign rsp_hi     = id_lat ? ID_GAP : RSP_MAX;
  assign rsp_tmo_at = id_lat ? ID_TMO : RSP_TMO;
  assign rsp_tmo    = rsp_pend && (d_cmd == rsp_tmo_at);
  assign rsp_bad    = rsp_pend &&
                      ((rsp_start && !win_ok(d_cmd, rsp_lo, rsp_hi)) || rsp_tmo);

  sd_tm_pend u_rsp_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (cmd_end),
    .clr  (rsp_start | rsp_tmo),
    .pend (rsp_pend)
  );

  // Stop spacing tracker and timeout.
  logic stop_pend, stop_tmo, stop_bad;
  assign stop_tmo = stop_pend && (d_stop == STOP_TMO);
  assign stop_bad = stop_pend && ((busy_end && d_stop != STOP_GAP) || stop_tmo);

  sd_tm_pend u_stop_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (stop_end),
    .clr  (busy_end | stop_tmo),
    .pend (stop_pend)
  );

  // Minimum-gap and window rules.
  logic rd_bad, rc_bad, cc_bad, wr_bad, any_bad;
  assign rd_bad  = rd_start && vld_cmd && !win_ok(d_cmd, RD_MIN, 32'(acc_limit));
  assign rc_bad  = cmd_start && vld_rsp && too_close(d_rsp, RSP2CMD_MIN);
  assign cc_bad  = cmd_start && vld_cmd && too_close(d_cmd, CMD2CMD_MIN);
  assign wr_bad  = wr_start && vld_rsp && too_close(d_rsp, WR_MIN);
  assign any_bad = rsp_bad | rd_bad | rc_bad | cc_bad | wr_bad | stop_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_rsp_lat    <= 1'b0;
      err_id_lat     <= 1'b0;
      err_rd_acc     <= 1'b0;
      err_rsp_to_cmd <= 1'b0;
      err_cmd_to_cmd <= 1'b0;
      err_wr_gap     <= 1'b0;
      err_stop_gap   <= 1'b0;
      err_any        <= 1'b0;
    end else begin
      err_rsp_lat    <= rsp_bad && !id_lat;
      err_id_lat     <= rsp_bad && id_lat;
      err_rd_acc     <= rd_bad;
      err_rsp_to_cmd <= rc_bad;
      err_cmd_to_cmd <= cc_bad;
      err_wr_gap     <= wr_bad;
      err_stop_gap   <= stop_bad;
      err_any        <= err_any | any_bad;
    end
  end
endmodule

// File: rtl/sd_tm_checker.sv
module sd_tm_checker #(
  parameter int CNT_W       = 16,
  parameter int RSP_MAX     = 64,
  parameter int ID_GAP      = 5,
  parameter int CMD2CMD_MIN = 8,
  parameter int WR_MIN      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_end,
  input logic             wr_start,
  input logic             rsp_pend,
  input logic             id_lat,
  input logic [CNT_W-1:0] gap_cmd,
  input logic [CNT_W-1:0] gap_rsp,
  input logic             vld_cmd,
  input logic             vld_rsp,
  input logic             err_rsp_lat,
  input logic             err_id_lat,
  input logic             err_rd_acc,
  input logic             err_rsp_to_cmd,
  input logic             err_cmd_to_cmd,
  input logic             err_wr_gap,
  input logic             err_stop_gap,
  input logic             err_any
);
  localparam logic [CNT_W-1:0] CEIL = '1;
  logic any_flag;
  assign any_flag = err_rsp_lat | err_id_lat | err_rd_acc | err_rsp_to_cmd |
                    err_cmd_to_cmd | err_wr_gap | err_stop_gap;

  AST_RSP_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pend && !id_lat && 32'(gap_cmd) == RSP_MAX + 1 |=> err_rsp_lat); // R2
  AST_ID_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pend && id_lat && 32'(gap_cmd) == ID_GAP + 1 |=> err_id_lat && !err_rsp_lat); // R3
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && vld_cmd && 32'(gap_cmd) < CMD2CMD_MIN |=> err_cmd_to_cmd); // R6
  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start && vld_rsp && 32'(gap_rsp) < WR_MIN |=> err_wr_gap); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_cmd && gap_cmd == CEIL && !cmd_end |=> gap_cmd == CEIL); // R9
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |-> err_any); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> err_any); // R10
endmodule

bind sd_timing_monitor sd_tm_checker #(
  .CNT_W(CNT_W), .RSP_MAX(RSP_MAX), .ID_GAP(ID_GAP),
  .CMD2CMD_MIN(CMD2CMD_MIN), .WR_MIN(WR_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
  .wr_start(wr_start), .rsp_pend(rsp_pend), .id_lat(id_lat),
  .gap_cmd(gap_cmd), .gap_rsp(gap_rsp), .vld_cmd(vld_cmd), .vld_rsp(vld_rsp),
  .err_rsp_lat(err_rsp_lat), .err_id_lat(err_id_lat), .err_rd_acc(err_rd_acc),
  .err_rsp_to_cmd(err_rsp_to_cmd), .err_cmd_to_cmd(err_cmd_to_cmd),
  .err_wr_gap(err_wr_gap), .err_stop_gap(err_stop_gap), .err_any(err_any)
);

// File: tb/sim_sd_timing_monitor.sv
`timescale 1ns/1ps
module sim_sd_timing_monitor;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_phase = 1'b0;
  logic [CNT_W-1:0] acc_limit = 8'd20;
  logic cmd_start = 0, cmd_end = 0, rsp_start = 0, rsp_end = 0;
  logic rd_start = 0, wr_start = 0, stop_end = 0, busy_end = 0;
  logic err_rsp_lat, err_id_lat, err_rd_acc, err_rsp_to_cmd;
  logic err_cmd_to_cmd, err_wr_gap, err_stop_gap, err_any;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_timing_monitor #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .id_phase(id_phase), .acc_limit(acc_limit),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .rsp_start(rsp_start),
    .rsp_end(rsp_end), .rd_start(rd_start), .wr_start(wr_start),
    .stop_end(stop_end), .busy_end(busy_end),
    .err_rsp_lat(err_rsp_lat), .err_id_lat(err_id_lat), .err_rd_acc(err_rd_acc),
    .err_rsp_to_cmd(err_rsp_to_cmd), .err_cmd_to_cmd(err_cmd_to_cmd),
    .err_wr_gap(err_wr_gap), .err_stop_gap(err_stop_gap), .err_any(err_any)
  );

  // Case kinds: 0 cmd_end->rsp_start, 1 cmd_end->rd_start, 2 rsp_end->cmd_start,
  // 3 cmd_end->cmd_start, 4 rsp_end->wr_start, 5 stop_end->busy_end,
  // 6 identification response.
  function automatic string tag_of(input int kind, input int d);
    case (kind)
      0: return (d > 64) ? "R2" : "R1";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic logic flag_of(input int kind);
    case (kind)
      0: return err_rsp_lat;
      1: return err_rd_acc;
      2: return err_rsp_to_cmd;
      3: return err_cmd_to_cmd;
      4: return err_wr_gap;
      5: return err_stop_gap;
      default: return err_id_lat;
    endcase
  endfunction

  function automatic int expect_of(input int kind, input int d, input int lim);
    case (kind)
      0: return (d < 2 || d > 64) ? 1 : 0;
      1: return (d < 2 || d > lim) ? 1 : 0;
      2: return (d < 8) ? 1 : 0;
      3: return (d < 8) ? 1 : 0;
      4: return (d < 2) ? 1 : 0;
      5: return (d != 2) ? 1 : 0;
      default: return (d != 5) ? 1 : 0;
    endcase
  endfunction

  task automatic set_a(input int kind, input logic v);
    case (kind)
      0, 1, 3, 6: cmd_end = v;
      2, 4: rsp_end = v;
      default: stop_end = v;
    endcase
  endtask

  task automatic set_b(input int kind, input logic v);
    case (kind)
      0, 6: rsp_start = v;
      1: rd_start = v;
      2, 3: cmd_start = v;
      4: wr_start = v;
      default: busy_end = v;
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Event A, then event B at distance d, then an idle tail. The target flag's
  // pulses are counted over the whole stretch.
  task automatic run_case(input int kind, input int d);
    int seen = 0;
    string what;
    @(negedge clk);
    id_phase = (kind == 6);
    set_a(kind, 1'b1);
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      seen += int'(flag_of(kind));
      set_a(kind, 1'b0);
      set_b(kind, i == d);
    end
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      seen += int'(flag_of(kind));
      set_b(kind, 1'b0);
      id_phase = 1'b0;
    end
    what = $sformatf("kind %0d distance %0d flag pulses", kind, d);
    check(tag_of(kind, d), what, seen, expect_of(kind, d, int'(acc_limit)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: everything is clear after reset.
    check("R10", "flags after reset",
          int'({err_rsp_lat, err_id_lat, err_rd_acc, err_rsp_to_cmd,
                err_cmd_to_cmd, err_wr_gap, err_stop_gap}), 0);
    check("R10", "err_any after reset", int'(err_any), 0);

    // R4: a read start before any command has ended is ignored.
    rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    check("R4", "read before any command", int'(err_rd_acc), 0);
    // R8: a busy end with no stop pending is ignored.
    busy_end = 1'b1;
    @(negedge clk); busy_end = 1'b0;
    check("R8", "busy end without stop", int'(err_stop_gap), 0);
    check("R10", "err_any still clear", int'(err_any), 0);

    for (int d = 1; d <= 70; d++) run_case(0, d);   // R1, R2
    for (int d = 1; d <= 8; d++)  run_case(6, d);   // R3
    for (int d = 1; d <= 24; d++) run_case(1, d);   // R4
    for (int d = 1; d <= 10; d++) run_case(2, d);   // R5
    for (int d = 1; d <= 10; d++) run_case(3, d);   // R6
    for (int d = 1; d <= 4; d++)  run_case(4, d);   // R7
    for (int d = 1; d <= 5; d++)  run_case(5, d);   // R8

    // R9: a read starting more than a full counter range late is still late.
    acc_limit = 8'd50;
    run_case(1, 300);
    acc_limit = 8'd20;

    // R10: sticky summary holds, and reset clears it.
    repeat (10) @(negedge clk);
    check("R10", "err_any sticky", int'(err_any), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "err_any after second reset", int'(err_any), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule